// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital half of a 10-bit successive-approximation converter on a microcontroller peripheral bus. Software starts a conversion with a start pulse, or a rising edge on an external trigger pin starts it. The sequencer then runs a fixed schedule of machine cycles: two to set the converter up, eight to sample the selected analog channel, and four for each of the ten bit decisions. The whole conversion takes 50 machine cycles. Machine-cycle boundaries are the clock edges on which `mc_en` is high. No other edge advances the sequence.

During each bit phase the block presents a trial code to the external DAC. The code holds the bits already decided, plus the bit under test. A single comparator input keeps or drops the bit under test. When the last bit is decided, the result is stored as an upper byte and two low bits, and a completion flag is raised. That flag also serves as the interrupt request.

While a conversion runs, or while a finished result is waiting, every new start request is thrown away. Entering idle or power-down aborts a conversion that is in progress. A result that has already completed is kept through either low-power state.

Top module: `sar_seq`

## Requirements
- R1: While reset is asserted, `busy`, `done`, `irq`, `sample_en`, `dac_code`, `res_hi` and `res_lo` are all zero.
- R2: A high `sw_start` on an enabled edge (`mc_en` high) starts a conversion when nothing blocks it. `busy` stays low through the first machine cycle and goes high at the enabled edge that ends that cycle.
- R3: The external pin starts a conversion when it is sampled high on an enabled edge after being sampled low on the previous enabled edge. A pin held high does not start a conversion again.
- R4: `sample_en` is high for exactly machine cycles 3 to 10 of a conversion. At the edge that ends cycle 50, `done` rises and `busy` falls together. `busy` and `done` are never high at the same time.
- R5: Bit phase j (j = 0..9, covering cycles 11+4j to 14+4j) presents `dac_code` = (bits already decided) | (1 << (9-j)). At the edge that ends cycle 14+4j, the bit is kept if `cmp_ge` is 1 and cleared otherwise. With a comparator that reports input >= `dac_code`, the result equals the input code. Outside bit phases the trial bit is absent: before the first decision of a conversion, `dac_code` is 0.
- R6: The result is presented as `res_hi` = result[9:2] and `res_lo` = result[1:0]. It is written only when a conversion completes and is unchanged while `done` is high.
- R7: A start request from either source is discarded, not queued, while a conversion is active (including its first cycle) or while `done` is high. Such a request does not change the timing or the result of a running conversion.
- R8: `clr_done` high on an enabled edge clears `done`. `irq` is high exactly while `done` is high.
- R9: `idle_req` or `pdown_req` high on an enabled edge during a conversion ends it at that edge, including on its first or last cycle. `busy` goes low, `done` is not set, and the previous result is unchanged.
- R10: While `idle_req` or `pdown_req` is high, `done` and the result are kept, and start requests are ignored.
- R11: `mux_sel` takes the value of `chan_sel` at the edge that starts a conversion and holds it until the next start.
- R12: No state changes on clock edges with `mc_en` low. A conversion lasts 50 enabled edges however far apart they are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mc_en | input | 1 | Machine-cycle enable; high on the edge that ends a machine cycle |
| sw_start | input | 1 | Software start request |
| ext_start | input | 1 | External start pin, rising-edge triggered |
| chan_sel | input | 3 | Analog channel to convert |
| clr_done | input | 1 | Software clear of the completion flag |
| idle_req | input | 1 | Idle mode active |
| pdown_req | input | 1 | Power-down mode active |
| cmp_ge | input | 1 | Comparator: analog input at or above DAC level |
| mux_sel | output | 3 | Analog multiplexer select |
| dac_code | output | 10 | Trial code for the DAC |
| sample_en | output | 1 | Sampling window of the input |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Conversion complete, result valid |
| irq | output | 1 | Interrupt request |
| res_hi | output | 8 | Upper 8 result bits |
| res_lo | output | 2 | Lower 2 result bits |

## Verification
A behavioural comparator converts every one of the 1024 input codes. A stuck, swapped or mis-timed bit decision therefore shows up as a wrong code for some input. A mid-scale input is traced cycle by cycle so that the sampling window, busy timing and trial-code progression are each separated from an off-by-one schedule. Start requests are injected in the first cycle, mid-conversion and while a result waits. Aborts are placed on the first, a middle and the last cycle, which tells a correctly blocked or cancelled conversion from one that queues, restarts or finishes early. A run with enables three clocks apart separates machine-cycle counting from clock counting.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_INIT,
    PH_SAMPLE,
    PH_BITS
  } sar_phase_e;
endpackage

// File: rtl/sar_start_gate.sv
module sar_start_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic mc_en,
  input  logic sw_start,
  input  logic ext_start,
  input  logic active,
  input  logic done,
  input  logic low_pwr,
  output logic start_go
);
  logic pin_q;
  logic pin_d;
  logic pin_rise;

  always_comb begin
    pin_d = mc_en ? ext_start : pin_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  // a rise is seen only between two enabled samples; blocked rises are lost
  assign pin_rise = ext_start & ~pin_q;
  assign start_go = mc_en & ~active & ~done & ~low_pwr & (sw_start | pin_rise);
endmodule

// File: rtl/sar_phase_ctl.sv
module sar_phase_ctl
  import sar_pkg::*;
#(
  parameter int RES_W      = 10,
  parameter int INIT_CYC   = 2,
  parameter int SAMPLE_CYC = 8,
  parameter int BIT_CYC    = 4,
  parameter int IDX_W      = $clog2(RES_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mc_en,
  input  logic             start_go,
  input  logic             low_pwr,
  input  logic             clr_done,
  output logic             active,
  output logic             in_bits,
  output logic             in_sample,
  output logic [IDX_W-1:0] bit_idx,
  output logic             decide,
  output logic             finish,
  output logic             busy,
  output logic             done
);
  localparam int CNT_MAX = (INIT_CYC > SAMPLE_CYC)
                         ? ((INIT_CYC > BIT_CYC) ? INIT_CYC : BIT_CYC)
                         : ((SAMPLE_CYC > BIT_CYC) ? SAMPLE_CYC : BIT_CYC);
  localparam int CNT_W = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] INIT_LAST   = CNT_W'(INIT_CYC - 1);
  localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_CYC - 1);
  localparam logic [CNT_W-1:0] BIT_LAST    = CNT_W'(BIT_CYC - 1);
  localparam logic [IDX_W-1:0] IDX_TOP     = IDX_W'(RES_W - 1);

  sar_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    busy_d  = busy_q;
    done_d  = done_q;
    decide  = 1'b0;
    finish  = 1'b0;
    if (mc_en) begin
      if (clr_done) done_d = 1'b0;
      if ((phase_q != PH_IDLE) && low_pwr) begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
        busy_d  = 1'b0;
      end else begin
        case (phase_q)
          PH_IDLE: begin
            if (start_go) begin
              phase_d = PH_INIT;
              cnt_d   = '0;
            end
          end
          PH_INIT: begin
            if (cnt_q == '0) busy_d = 1'b1;
            if (cnt_q == INIT_LAST) begin
              phase_d = PH_SAMPLE;
              cnt_d   = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          PH_SAMPLE: begin
            if (cnt_q == SAMPLE_LAST) begin
              phase_d = PH_BITS;
              cnt_d   = '0;
              idx_d   = IDX_TOP;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          PH_BITS: begin
            if (cnt_q == BIT_LAST) begin
              decide = 1'b1;
              cnt_d  = '0;
              if (idx_q == '0) begin
                finish  = 1'b1;
                phase_d = PH_IDLE;
                busy_d  = 1'b0;
                done_d  = 1'b1;
              end else begin
                idx_d = idx_q - 1'b1;
              end
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
          default: phase_d = PH_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
    end
  end

  assign active    = (phase_q != PH_IDLE);
  assign in_bits   = (phase_q == PH_BITS);
  assign in_sample = (phase_q == PH_SAMPLE);
  assign bit_idx   = idx_q;
  assign busy      = busy_q;
  assign done      = done_q;
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int RES_W = 10,
  parameter int IDX_W = $clog2(RES_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_go,
  input  logic             decide,
  input  logic             finish,
  input  logic             in_bits,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             cmp_ge,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] result
);
  logic [RES_W-1:0] sar_q, sar_d;
  logic [RES_W-1:0] res_q, res_d;
  logic [RES_W-1:0] trial;

  always_comb begin
    trial = in_bits ? (RES_W'(1) << bit_idx) : '0;
  end

  always_comb begin
    sar_d = sar_q;
    res_d = res_q;
    if (start_go)    sar_d = '0;
    else if (decide) sar_d[bit_idx] = cmp_ge;
    if (finish)      res_d = sar_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar_q <= '0;
      res_q <= '0;
    end else begin
      sar_q <= sar_d;
      res_q <= res_d;
    end
  end

  assign dac_code = sar_q | trial;
  assign result   = res_q;
endmodule

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int RES_W      = 10,
  parameter int CH_W       = 3,
  parameter int INIT_CYC   = 2,
  parameter int SAMPLE_CYC = 8,
  parameter int BIT_CYC    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mc_en,
  input  logic             sw_start,
  input  logic             ext_start,
  input  logic [CH_W-1:0]  chan_sel,
  input  logic             clr_done,
  input  logic             idle_req,
  input  logic             pdown_req,
  input  logic             cmp_ge,
  output logic [CH_W-1:0]  mux_sel,
  output logic [RES_W-1:0] dac_code,
  output logic             sample_en,
  output logic             busy,
  output logic             done,
  output logic             irq,
  output logic [RES_W-3:0] res_hi,
  output logic [1:0]       res_lo
);
  localparam int IDX_W = $clog2(RES_W);

  logic             rst_meta, rst_sync;
  logic             low_pwr;
  logic             start_go;
  logic             active;
  logic             in_bits;
  logic [IDX_W-1:0] bit_idx;
  logic             decide;
  logic             finish;
  logic [RES_W-1:0] result;
  logic [CH_W-1:0]  mux_q, mux_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign low_pwr = idle_req | pdown_req;

  sar_start_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_sync),
    .mc_en     (mc_en),
    .sw_start  (sw_start),
    .ext_start (ext_start),
    .active    (active),
    .done      (done),
    .low_pwr   (low_pwr),
    .start_go  (start_go)
  );

  sar_phase_ctl #(
    .RES_W      (RES_W),
    .INIT_CYC   (INIT_CYC),
    .SAMPLE_CYC (SAMPLE_CYC),
    .BIT_CYC    (BIT_CYC),
    .IDX_W      (IDX_W)
  ) u_ctl (
    .clk       (clk),
    .rst_n     (rst_sync),
    .mc_en     (mc_en),
    .start_go  (start_go),
    .low_pwr   (low_pwr),
    .clr_done  (clr_done),
    .active    (active),
    .in_bits   (in_bits),
    .in_sample (sample_en),
    .bit_idx   (bit_idx),
    .decide    (decide),
    .finish    (finish),
    .busy      (busy),
    .done      (done)
  );

  sar_approx #(
    .RES_W (RES_W),
    .IDX_W (IDX_W)
  ) u_sar (
    .clk      (clk),
    .rst_n    (rst_sync),
    .start_go (start_go),
    .decide   (decide),
    .finish   (finish),
    .in_bits  (in_bits),
    .bit_idx  (bit_idx),
    .cmp_ge   (cmp_ge),
    .dac_code (dac_code),
    .result   (result)
  );

  always_comb begin
    mux_d = start_go ? chan_sel : mux_q;
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) mux_q <= '0;
    else           mux_q <= mux_d;
  end

  assign mux_sel = mux_q;
  assign irq     = done;
  assign res_hi  = result[RES_W-1:2];
  assign res_lo  = result[1:0];
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES_W = 10,
  parameter int CH_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mc_en,
  input logic             idle_req,
  input logic             pdown_req,
  input logic [CH_W-1:0]  mux_sel,
  input logic [RES_W-1:0] dac_code,
  input logic             sample_en,
  input logic             busy,
  input logic             done,
  input logic [RES_W-3:0] res_hi,
  input logic [1:0]       res_lo
);
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R4

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $fell(busy)); // R4

  AST_SAMPLE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> busy); // R4

  AST_BUSY_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(mc_en)); // R2

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable({res_hi, res_lo})); // R6

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mc_en && (idle_req || pdown_req)) |=> (!busy && !done)); // R9

  AST_MUX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mux_sel)); // R11

  AST_NO_IDLE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    !mc_en |=> $stable({busy, done, sample_en, dac_code})); // R12
endmodule

bind sar_seq sar_seq_chk #(.RES_W(RES_W), .CH_W(CH_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mc_en     (mc_en),
  .idle_req  (idle_req),
  .pdown_req (pdown_req),
  .mux_sel   (mux_sel),
  .dac_code  (dac_code),
  .sample_en (sample_en),
  .busy      (busy),
  .done      (done),
  .res_hi    (res_hi),
  .res_lo    (res_lo)
);

// File: tb/sar_seq_bench.sv
`timescale 1ns/1ps
module sar_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mc_en;
  logic       sw_start;
  logic       ext_start;
  logic [2:0] chan_sel;
  logic       clr_done;
  logic       idle_req;
  logic       pdown_req;
  logic       cmp_ge;
  logic [2:0] mux_sel;
  logic [9:0] dac_code;
  logic       sample_en;
  logic       busy;
  logic       done;
  logic       irq;
  logic [7:0] res_hi;
  logic [1:0] res_lo;
  logic [9:0] vin;

  int checks = 0;
  int fails  = 0;
  int div    = 1;

  always #2 clk = ~clk;

  // behavioural comparator: input at or above DAC level
  assign cmp_ge = (vin >= dac_code);

  sar_seq u_sar_seq (
    .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .sw_start(sw_start),
    .ext_start(ext_start), .chan_sel(chan_sel), .clr_done(clr_done),
    .idle_req(idle_req), .pdown_req(pdown_req), .cmp_ge(cmp_ge),
    .mux_sel(mux_sel), .dac_code(dac_code), .sample_en(sample_en),
    .busy(busy), .done(done), .irq(irq), .res_hi(res_hi), .res_lo(res_lo)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one machine cycle: div-1 disabled clocks, then one enabled edge
  task automatic mc();
    repeat (div - 1) begin
      mc_en = 1'b0;
      @(negedge clk);
    end
    mc_en = 1'b1;
    @(negedge clk);
    mc_en = 1'b0;
  endtask

  task automatic mcn(input int n);
    repeat (n) mc();
  endtask

  task automatic start_sw();
    sw_start = 1'b1;
    mc();
    sw_start = 1'b0;
  endtask

  task automatic clear();
    clr_done = 1'b1;
    mc();
    clr_done = 1'b0;
  endtask

  task automatic run_conv(input int v, input int ch);
    vin = 10'(v);
    chan_sel = 3'(ch);
    start_sw();
    mcn(50);
  endtask

  function automatic int res_val();
    return int'({res_hi, res_lo});
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mc_en = 1'b0; sw_start = 1'b0; ext_start = 1'b0;
    chan_sel = 3'd0; clr_done = 1'b0; idle_req = 1'b0; pdown_req = 1'b0;
    vin = 10'd0;
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 sample_en", int'(sample_en), 0);
    chk("R1 dac_code", int'(dac_code), 0);
    chk("R1 result", res_val(), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // cycle-by-cycle trace, input 700, channel 5
    vin = 10'd700; chan_sel = 3'd5;
    start_sw();
    chk("R2 busy low in cycle 1", int'(busy), 0);
    mc();
    chk("R2 busy after cycle 1", int'(busy), 1);
    chk("R4 no sampling in cycle 2", int'(sample_en), 0);
    mc();
    chk("R4 sampling cycle 3", int'(sample_en), 1);
    mcn(7);
    chk("R4 sampling cycle 10", int'(sample_en), 1);
    chk("R5 dac before bits", int'(dac_code), 0);
    mc();
    chk("R4 sampling over", int'(sample_en), 0);
    chk("R5 first trial", int'(dac_code), 512);
    chk("R11 mux_sel", int'(mux_sel), 5);
    chan_sel = 3'd2;
    mcn(4);
    chk("R5 second trial", int'(dac_code), 768);
    mcn(35);
    chk("R4 busy cycle 50", int'(busy), 1);
    chk("R4 done cycle 50", int'(done), 0);
    mc();
    chk("R4 done at end", int'(done), 1);
    chk("R4 busy at end", int'(busy), 0);
    chk("R8 irq with done", int'(irq), 1);
    chk("R6 res_hi", int'(res_hi), 175);
    chk("R6 res_lo", int'(res_lo), 0);
    chk("R11 mux held", int'(mux_sel), 5);

    // starts while done is high are lost
    vin = 10'd100;
    start_sw();
    mc();
    chk("R7 sw start while done", int'(busy), 0);
    chk("R6 result kept", res_val(), 700);
    ext_start = 1'b1;
    mcn(2);
    chk("R7 pin start while done", int'(busy), 0);
    clear();
    chk("R8 done cleared", int'(done), 0);
    chk("R8 irq cleared", int'(irq), 0);
    mcn(2);
    chk("R3 held pin no start", int'(busy), 0);
    ext_start = 1'b0;
    mc();
    ext_start = 1'b1;
    mc();
    ext_start = 1'b0;
    mc();
    chk("R3 pin rise starts", int'(busy), 1);
    mcn(49);
    chk("R3 pin conversion done", int'(done), 1);
    chk("R3 pin conversion result", res_val(), 100);
    clear();

    // starts during a conversion are discarded
    vin = 10'd300; chan_sel = 3'd1;
    start_sw();
    sw_start = 1'b1;
    mc();
    sw_start = 1'b0;
    mcn(5);
    ext_start = 1'b0;
    mc();
    ext_start = 1'b1;
    mc();
    ext_start = 1'b0;
    sw_start = 1'b1;
    mc();
    sw_start = 1'b0;
    mcn(40);
    chk("R7 timing kept cycle 50", int'(done), 0);
    mc();
    chk("R7 timing kept end", int'(done), 1);
    chk("R7 result kept", res_val(), 300);
    clear();
    mcn(3);
    chk("R7 no queued start", int'(busy), 0);

    // aborts
    vin = 10'd400;
    start_sw();
    mcn(20);
    idle_req = 1'b1;
    mc();
    idle_req = 1'b0;
    chk("R9 idle abort busy", int'(busy), 0);
    mcn(60);
    chk("R9 idle abort no done", int'(done), 0);
    chk("R9 idle abort result", res_val(), 300);
    start_sw();
    mcn(49);
    pdown_req = 1'b1;
    mc();
    pdown_req = 1'b0;
    chk("R9 last cycle abort busy", int'(busy), 0);
    chk("R9 last cycle abort done", int'(done), 0);
    mcn(3);
    chk("R9 last cycle abort later", int'(done), 0);
    chk("R9 last cycle abort result", res_val(), 300);
    start_sw();
    idle_req = 1'b1;
    mc();
    idle_req = 1'b0;
    mcn(55);
    chk("R9 first cycle abort busy", int'(busy), 0);
    chk("R9 first cycle abort done", int'(done), 0);

    // low-power keeps a result and blocks starts
    run_conv(555, 3);
    chk("R10 done before idle", int'(done), 1);
    idle_req = 1'b1;
    mcn(10);
    chk("R10 done kept in idle", int'(done), 1);
    chk("R10 result kept in idle", res_val(), 555);
    clear();
    start_sw();
    mcn(2);
    chk("R10 start ignored in idle", int'(busy), 0);
    idle_req = 1'b0;
    pdown_req = 1'b1;
    start_sw();
    mcn(2);
    chk("R10 start ignored in power-down", int'(busy), 0);
    pdown_req = 1'b0;

    // every channel
    for (int ch = 0; ch < 8; ch++) begin
      run_conv(ch * 100 + 7, ch);
      chk("R11 channel captured", int'(mux_sel), ch);
      chk("R5 channel result", res_val(), ch * 100 + 7);
      clear();
    end

    // exhaustive input sweep
    for (int v = 0; v < 1024; v++) begin
      run_conv(v, v % 8);
      chk("R6 sweep res_hi", int'(res_hi), v / 4);
      chk("R6 sweep res_lo", int'(res_lo), v % 4);
      clear();
    end

    // enables three clocks apart
    div = 3;
    vin = 10'd813;
    start_sw();
    mcn(49);
    chk("R12 spaced busy cycle 50", int'(busy), 1);
    chk("R12 spaced done cycle 50", int'(done), 0);
    mc();
    chk("R12 spaced done", int'(done), 1);
    chk("R12 spaced result", res_val(), 813);
    clear();
    div = 1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule